// File: doc/BRIEF.md
# Subcode Block Sync and Q-Channel Extractor

This block sits after the EFM demodulator of an optical-disc read channel. Once per frame it receives the demodulated 8-bit subcode symbol on a frame strobe. Each symbol comes with two flags that mark the two block-sync patterns, called first sync and second sync here. The block finds the start of each 98-frame subcode block: a first-sync frame followed directly by a second-sync frame. It marks that start with a block-start level, one frame after the first sync symbol.

During each block the Q bit is taken from every data symbol. It is presented as a serial bit with a strobe, and it is packed into bytes. Each finished byte is loaded into an 8-bit readout register, which an external readout clock shifts out MSB first. The 96 Q bits of a block are checked with a CRC-16. The pass/fail flag appears together with the next block-start and holds until the block-start after that.

Top module: `subq_extract`

## Requirements
- R1: `blk_start` rises after a strobe whose symbol carries the second-sync flag, when the strobe just before it carried the first-sync flag. It stays high until the next strobe and then falls, unless that strobe completes another such pair.
- R2: A second-sync symbol whose previous strobe was not first-sync does not raise `blk_start`. Neither does a first-sync symbol followed by any symbol that is not second-sync.
- R3: `sync_out` is high after a sync symbol only while `blk_start` is high, and it is never high otherwise.
- R4: The Q bit is bit 6 of `sub_sym` (bit 7 is P, bit 0 is W). After a block start, each of the first 96 strobes that carry no sync flag updates `q_ser` and gives a one-cycle `q_stb` pulse. The following strobes give no pulse: sync strobes, strobes after the 96th data strobe, and strobes before the first block start.
- R5: After every 8th Q bit of a block, that byte is loaded into the readout register, with the earliest Q bit at bit 7. `byte_ld` pulses for one cycle, and `rd_dout` shows bit 7 of the register.
- R6: Each rising edge of `rd_sclk`, sampled in the `clk` domain, shifts the readout register one place toward bit 7 and fills bit 0 with zero. A byte load in the same cycle takes priority over the shift.
- R7: At each block start, `crc_ok` becomes 1 only when all of the following hold: the previous block delivered all 96 Q bits, and the CRC-16 of its first 80 Q bits equals the bitwise inverse of its last 16 Q bits. The CRC uses polynomial x^16+x^12+x^5+1 (0x1021), initial value 0, earliest bit first. In every other case `crc_ok` becomes 0.
- R8: `crc_ok` changes only when a block start occurs.
- R9: During synchronous active-low reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_stb | input | 1 | One-cycle frame strobe; the symbol and flags are valid with it |
| sub_sym | input | 8 | Demodulated subcode symbol, P in bit 7 to W in bit 0 |
| sym_s0 | input | 1 | Symbol is the first block-sync pattern |
| sym_s1 | input | 1 | Symbol is the second block-sync pattern |
| rd_sclk | input | 1 | External readout clock, slow and sampled in `clk` |
| blk_start | output | 1 | Block-start level, one frame long |
| sync_out | output | 1 | Sync-symbol indication, gated by block start |
| q_ser | output | 1 | Latest Q bit |
| q_stb | output | 1 | Pulse when `q_ser` takes a new Q bit |
| byte_ld | output | 1 | Pulse when a Q byte enters the readout register |
| rd_dout | output | 1 | Serial output of the readout register |
| crc_ok | output | 1 | Q CRC result of the previous block, 1 = good |

## Verification
The bench sends stray second-sync symbols and a first-sync symbol followed by data. A pair detector that ignores order would raise a block start on these. Blocks are sent with a correct check word, with one flipped Q bit, cut short at 50 data frames, and padded with ten extra frames. A checker that uses a non-inverted check word or counts the extra frames would report the wrong flag. Readout clock edges fall between byte loads, so missing zero fill or a lost load priority shows up on `rd_dout`. A flag that moves between block starts also shows up in the every-cycle compare.

// File: rtl/subq_pkg.sv
// Shared constants and the serial CRC step for the subcode Q extractor.
// Assumes earliest-bit-first CRC division with a zero initial value.
package subq_pkg;
    parameter int SYM_W    = 8;
    parameter int Q_POS    = 6;
    parameter int Q_BITS   = 96;
    parameter int CRC_W    = 16;
    parameter int BYTE_W   = 8;
    parameter logic [15:0] CRC_POLY = 16'h1021;

    localparam int DATA_BITS = Q_BITS - CRC_W;
    localparam int CNT_W     = $clog2(Q_BITS + 1);
    localparam int BIDX_W    = $clog2(BYTE_W);

    // One CRC division step for a single input bit.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY[CRC_W-1:0] : '0);
    endfunction
endpackage

// File: rtl/subq_sync_det.sv
// Block-sync pair detector. Raises a frame-long block-start level after a
// second-sync strobe that directly follows a first-sync strobe.
// Assumes the two sync flags are never both set on one strobe.
module subq_sync_det (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_stb,
    input  logic sym_s0,
    input  logic sym_s1,
    output logic blk_set,
    output logic data_stb,
    output logic blk_start,
    output logic sync_out
);
    logic prev_s0;
    logic blk_q;
    logic sync_q;

    // Block begins on the second-sync strobe right after a first-sync strobe.
    assign blk_set  = frm_stb & sym_s1 & prev_s0;
    // Strobes that carry no sync flag are data frames.
    assign data_stb = frm_stb & ~sym_s0 & ~sym_s1;

    // Remember the last frame's sync flag and hold block start for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_s0 <= 1'b0;
            blk_q   <= 1'b0;
            sync_q  <= 1'b0;
        end else if (frm_stb) begin
            prev_s0 <= sym_s0;
            blk_q   <= blk_set;
            sync_q  <= blk_set & (sym_s0 | sym_s1);
        end
    end

    assign blk_start = blk_q;
    assign sync_out  = sync_q;

    // R1
    blk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_start) |-> $past(frm_stb && sym_s1));
    // R1
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |=> $stable(blk_start));
endmodule

// File: rtl/subq_assemble.sv
// Q-channel assembler. Collects up to Q_BITS Q bits per block, raises a
// byte-load request on every byte boundary and checks the CRC, whose result
// is latched at the next block start. Check bits arrive inverted.
module subq_assemble
    import subq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_set,
    input  logic              data_stb,
    input  logic              q_in,
    output logic              q_ser,
    output logic              q_stb,
    output logic              ld_req,
    output logic [BYTE_W-1:0] ld_byte,
    output logic              crc_ok
);
    localparam logic [CNT_W-1:0] QMAX  = CNT_W'(Q_BITS);
    localparam logic [CNT_W-1:0] DMAX  = CNT_W'(DATA_BITS);

    logic              in_blk;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] acc;
    logic [CRC_W-1:0]  crc;
    logic              take;
    logic              div_bit;

    // Accept a Q bit only inside a block and below the field length.
    assign take    = data_stb & in_blk & (cnt < QMAX);
    // Check bits are stored inverted, so undo that before dividing.
    assign div_bit = (cnt < DMAX) ? q_in : ~q_in;
    assign ld_req  = take & (cnt[BIDX_W-1:0] == '1);
    assign ld_byte = {acc, q_in};

    // Bit counter, byte accumulator, CRC register and latched result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_blk <= 1'b0;
            cnt    <= '0;
            acc    <= '0;
            crc    <= '0;
            q_ser  <= 1'b0;
            q_stb  <= 1'b0;
            crc_ok <= 1'b0;
        end else begin
            q_stb <= take;
            if (blk_set) begin
                crc_ok <= in_blk && (cnt == QMAX) && (crc == '0);
                in_blk <= 1'b1;
                cnt    <= '0;
                crc    <= '0;
            end else if (take) begin
                cnt   <= cnt + CNT_W'(1);
                acc   <= {acc[BYTE_W-3:0], q_in};
                crc   <= crc_step(crc, div_bit);
                q_ser <= q_in;
            end
        end
    end

    // R8
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_set |=> $stable(crc_ok));
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= QMAX);
endmodule

// File: rtl/subq_readout.sv
// Byte readout register. Loads a Q byte on request and shifts it toward the
// MSB on each rising edge of an external clock that is sampled in clk.
// Assumes that clock is slow against clk; a load wins over a shift.
module subq_readout
    import subq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sclk,
    input  logic              ld_req,
    input  logic [BYTE_W-1:0] ld_byte,
    output logic              rd_dout,
    output logic              byte_ld
);
    logic              sclk_q;
    logic              rise;
    logic [BYTE_W-1:0] sr;

    assign rise = rd_sclk & ~sclk_q;

    // Edge detector, load/shift register and load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sr      <= '0;
            byte_ld <= 1'b0;
        end else begin
            sclk_q  <= rd_sclk;
            byte_ld <= ld_req;
            if (ld_req)
                sr <= ld_byte;
            else if (rise)
                sr <= {sr[BYTE_W-2:0], 1'b0};
        end
    end

    assign rd_dout = sr[BYTE_W-1];

    // R6
    sr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_req && !rise) |=> $stable(sr));
endmodule

// File: rtl/subq_extract.sv
// Subcode block sync and Q extractor top. Connects the pair detector, the Q
// assembler and the readout register. Only the Q bit of each symbol is used.
module subq_extract
    import subq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_stb,
    input  logic [SYM_W-1:0] sub_sym,
    input  logic             sym_s0,
    input  logic             sym_s1,
    input  logic             rd_sclk,
    output logic             blk_start,
    output logic             sync_out,
    output logic             q_ser,
    output logic             q_stb,
    output logic             byte_ld,
    output logic             rd_dout,
    output logic             crc_ok
);
    logic              blk_set;
    logic              data_stb;
    logic              ld_req;
    logic [BYTE_W-1:0] ld_byte;
    logic              sym_unused;

    // The P and R..W channels pass through unused.
    assign sym_unused = ^(sub_sym & ~(SYM_W'(1) << Q_POS));

    subq_sync_det u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_stb   (frm_stb),
        .sym_s0    (sym_s0),
        .sym_s1    (sym_s1),
        .blk_set   (blk_set),
        .data_stb  (data_stb),
        .blk_start (blk_start),
        .sync_out  (sync_out)
    );

    subq_assemble u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_set  (blk_set),
        .data_stb (data_stb),
        .q_in     (sub_sym[Q_POS]),
        .q_ser    (q_ser),
        .q_stb    (q_stb),
        .ld_req   (ld_req),
        .ld_byte  (ld_byte),
        .crc_ok   (crc_ok)
    );

    subq_readout u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sclk (rd_sclk),
        .ld_req  (ld_req),
        .ld_byte (ld_byte),
        .rd_dout (rd_dout),
        .byte_ld (byte_ld)
    );

    // R3
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> blk_start);
    // R4
    qstb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_stb |-> $past(frm_stb && !sym_s0 && !sym_s1));
    // R5
    byte_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ld |-> q_stb);
endmodule

// File: tb/sim_subq_extract.sv
module sim_subq_extract;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       frm_stb = 1'b0, sym_s0 = 1'b0, sym_s1 = 1'b0, rd_sclk = 1'b0;
    logic [7:0] sub_sym = '0;
    logic       blk_start, sync_out, q_ser, q_stb, byte_ld, rd_dout, crc_ok;

    subq_extract u0 (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .sub_sym(sub_sym),
        .sym_s0(sym_s0), .sym_s1(sym_s1), .rd_sclk(rd_sclk),
        .blk_start(blk_start), .sync_out(sync_out), .q_ser(q_ser),
        .q_stb(q_stb), .byte_ld(byte_ld), .rd_dout(rd_dout), .crc_ok(crc_ok)
    );

    int n_vec = 0;
    int n_err = 0;

    // Behavioural reference state
    bit       m_prev_s0, m_blk, m_sync, m_inblk, m_q, m_qstb, m_bld, m_crc, m_sclk_prev;
    bit [7:0] m_rd;
    bit       mq[$];
    bit       blkq[96];

    function automatic bit [15:0] crc_of_queue(int n);
        bit [15:0] c = 16'h0;
        for (int i = 0; i < n; i++) begin
            bit fb = c[15] ^ mq[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic bit [15:0] crc_of_blk();
        bit [15:0] c = 16'h0;
        for (int i = 0; i < 80; i++) begin
            bit fb = c[15] ^ blkq[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic model_step(bit stb, bit [7:0] sym, bit s0, bit s1, bit sclk);
        bit rise;
        bit load;
        bit [15:0] par;
        rise = sclk && !m_sclk_prev;
        m_sclk_prev = sclk;
        load = 0; m_qstb = 0; m_bld = 0;
        if (stb) begin
            if (s1 && m_prev_s0) begin
                if (m_inblk && mq.size() == 96) begin
                    for (int i = 0; i < 16; i++) par[15-i] = mq[80+i];
                    m_crc = (crc_of_queue(80) == ~par);
                end else m_crc = 0;
                mq.delete();
                m_inblk = 1; m_blk = 1; m_sync = 1;
            end else begin
                m_blk = 0; m_sync = 0;
                if (!s0 && !s1 && m_inblk && mq.size() < 96) begin
                    mq.push_back(sym[6]);
                    m_q = sym[6]; m_qstb = 1;
                    if (mq.size() % 8 == 0) begin
                        for (int i = 0; i < 8; i++) m_rd[7-i] = mq[mq.size()-8+i];
                        load = 1; m_bld = 1;
                    end
                end
            end
            m_prev_s0 = s0;
        end
        if (!load && rise) m_rd = {m_rd[6:0], 1'b0};
    endtask

    task automatic chk(string what, logic act, bit exp);
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic compare();
        n_vec++;
        if (!rst_n) begin
            // R9: every output is 0 in reset
            chk("R9 blk_start", blk_start, 0); chk("R9 sync_out", sync_out, 0);
            chk("R9 q_ser", q_ser, 0);         chk("R9 q_stb", q_stb, 0);
            chk("R9 byte_ld", byte_ld, 0);     chk("R9 rd_dout", rd_dout, 0);
            chk("R9 crc_ok", crc_ok, 0);
        end else begin
            chk("R1/R2 blk_start", blk_start, m_blk);
            chk("R3 sync_out", sync_out, m_sync);
            chk("R4 q_ser", q_ser, m_q);
            chk("R4 q_stb", q_stb, m_qstb);
            chk("R5 byte_ld", byte_ld, m_bld);
            chk("R5/R6 rd_dout", rd_dout, m_rd[7]);
            chk("R7/R8 crc_ok", crc_ok, m_crc);
        end
    endtask

    task automatic tick(bit stb, bit [7:0] sym, bit s0, bit s1, bit sclk);
        frm_stb = stb; sub_sym = sym; sym_s0 = s0; sym_s1 = s1; rd_sclk = sclk;
        if (rst_n) model_step(stb, sym, s0, s1, sclk);
        @(posedge clk);
        #1;
        compare();
    endtask

    // One frame: strobe, then a gap carrying two readout clock edges.
    task automatic frame(bit [7:0] sym, bit s0, bit s1);
        tick(1, sym, s0, s1, 0);
        tick(0, 8'h00, 0, 0, 1);
        tick(0, 8'h00, 0, 0, 0);
        tick(0, 8'h00, 0, 0, 1);
    endtask

    task automatic data_frame(bit q);
        bit [7:0] s;
        s = 8'($urandom);
        s[6] = q;
        frame(s, 0, 0);
    endtask

    task automatic sync_pair();
        frame(8'($urandom), 1, 0);
        frame(8'($urandom), 0, 1);
    endtask

    // Build a block with a good check word, optionally flip one bit, send n frames.
    task automatic send_block(int nframes, int flip);
        bit [15:0] c;
        for (int i = 0; i < 80; i++) blkq[i] = 1'($urandom);
        c = ~crc_of_blk();
        for (int i = 0; i < 16; i++) blkq[80+i] = c[15-i];
        if (flip >= 0) blkq[flip] = ~blkq[flip];
        for (int i = 0; i < nframes; i++) data_frame(i < 96 ? blkq[i] : 1'($urandom));
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        // R9: reset state
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) tick(0, 8'h00, 0, 0, 0);
        rst_n = 1'b1;
        tick(0, 8'h00, 0, 0, 0);

        // R4: data before any block start gives no Q output
        for (int i = 0; i < 5; i++) data_frame(1'b1);
        // R2: stray second sync, then first sync followed by data
        frame(8'h55, 0, 1);
        frame(8'hAA, 1, 0);
        data_frame(1'b1);
        frame(8'h11, 0, 1);
        frame(8'h22, 0, 1);

        // R1/R3: first real block; R4/R5/R6 during its 96 frames
        sync_pair();
        send_block(96, -1);
        // R7: good block reported at next start
        sync_pair();
        // R7: one flipped bit in the data part
        send_block(96, 37);
        sync_pair();
        // R7: flipped bit in the check word
        send_block(96, 90);
        sync_pair();
        // R7: short block
        send_block(50, -1);
        sync_pair();
        // R4/R7: extra frames after 96 ignored, result still good
        send_block(106, -1);
        sync_pair();
        // R8: flag held across a full following block
        send_block(96, -1);
        frame(8'h00, 1, 0);
        frame(8'h40, 1, 0);
        sync_pair();
        for (int i = 0; i < 6; i++) tick(0, 8'h00, 0, 0, (i % 2) == 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule